// File: doc/BRIEF.md
# CAN FD Transmitter Delay Compensator

A transmitting CAN FD node reads its own bits back from the bus. At fast data-phase bit rates, the loop through the transceiver can take longer than a whole bit. The regular sample point then no longer sees the bit that was just sent. This block finds that loop delay once per frame. It times how long the dominant edge that opens the reserved bit takes to return on the receive line, counting in minimum time quanta (one period of the quantum clock enable).

From the measured delay plus a programmable offset it derives a secondary sample point. Each data-phase bit is stored with its launch time in a short queue. When the bit's secondary sample point arrives, the stored level is compared with the receive line. A mismatch is held and reported to the protocol engine at the following regular sample point.

The protocol engine supplies the strobes that mark the edge to time, each bit launch, each regular sample point and the extent of the data phase. Bit timing, framing, CRC and arbitration stay outside this block.

Top module: `txdc_top`

## Requirements
- R1: After reset, and after any quantum in which `init` is high, `delay_val` reads 0.
- R2: With `comp_en` high, a quantum carrying `fdf_edge` starts a measurement. `delay_val` becomes the number of quanta from that quantum to the first later quantum in which `rx_level` is 0 after being 1 in the quantum before.
- R3: If no such receive edge has appeared 127 quanta after the start, `delay_val` becomes 127 and later edges are ignored.
- R4: `delay_val` holds its value until the next measurement completes. A strobe on `fdf_edge` while `comp_en` is low starts no measurement.
- R5: The secondary sample point offset S is `delay_val + tdc_offset`, capped at 127 and raised to 1 when the sum is 0. A bit launched in quantum L (marked by `bit_start`, level taken from `tx_level`) is compared with `rx_level` in quantum L+S.
- R6: A mismatch raises `bit_err` for one clock, in the quantum of the first `sample_pt` strictly later than the mismatch. A mismatch found in a `sample_pt` quantum is therefore reported at the following one.
- R7: No comparison takes place while `data_phase` or `comp_en` is low. Bits whose secondary sample point falls after `data_phase` drops are discarded. A mismatch still pending when the data phase ends is dropped.
- R8: At least 6 launched bits can await their secondary sample points at once (default queue depth 8), and each is checked in launch order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tq_en | input | 1 | One-clock enable per minimum time quantum |
| init | input | 1 | Initialization request; clears the measured value and stops checking |
| comp_en | input | 1 | Compensation enable |
| tdc_offset | input | 7 | Offset in quanta added to the measured delay |
| tx_level | input | 1 | Level being driven on the transmit pin |
| rx_level | input | 1 | Level seen on the receive pin |
| fdf_edge | input | 1 | Quantum in which the transmit line falls from the FD-format bit to the reserved bit |
| bit_start | input | 1 | Quantum in which a data-phase bit is launched |
| data_phase | input | 1 | High through the sample point of the CRC delimiter |
| sample_pt | input | 1 | Regular sample point quantum |
| delay_val | output | 7 | Measured transmitter delay in quanta |
| bit_err | output | 1 | One-clock bit-error report at a regular sample point |

## Verification
A wrong measurement counter or state shows directly on `delay_val`, a few quanta after the returning edge, and no later than 128 quanta after the strobe. A stale or misaligned queue entry makes a compare happen against the wrong bit or in the wrong quantum. It then shows up as a `bit_err` pulse at the wrong regular sample point, usually within one data bit time. A pending flag that is not cleared when the data phase ends shows up as a spurious pulse in the next frame. The bench therefore pairs each expected pulse with the exact quantum index it should occur in.

// File: rtl/txdc_pkg.sv
package txdc_pkg;
  localparam int unsigned TQ_W   = 7;
  localparam int unsigned TQ_MAX = (1 << TQ_W) - 1;

  typedef logic [TQ_W-1:0] tq_t;

  typedef struct packed {
    logic bit_val;
    tq_t  due;
  } slot_t;
endpackage

// File: rtl/txdc_meter.sv
module txdc_meter
  import txdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tq_en,
  input  logic init,
  input  logic comp_en,
  input  logic fdf_edge,
  input  logic rx_level,
  output tq_t  delay_val
);
  typedef enum logic {M_IDLE, M_RUN} mst_t;

  mst_t st_q, st_d;
  tq_t  cnt_q, cnt_d;
  tq_t  val_q, val_d;
  logic rx_prev_q, rx_prev_d;
  logic rx_fall;

  assign rx_fall = rx_prev_q & ~rx_level;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    val_d     = val_q;
    rx_prev_d = rx_prev_q;
    if (tq_en) begin
      rx_prev_d = rx_level;
      if (init) begin
        st_d  = M_IDLE;
        cnt_d = '0;
        val_d = '0;
      end else begin
        case (st_q)
          M_IDLE: begin
            if (comp_en && fdf_edge) begin
              st_d  = M_RUN;
              cnt_d = tq_t'(1);
            end
          end
          M_RUN: begin
            if (rx_fall) begin
              val_d = cnt_q;
              st_d  = M_IDLE;
            end else if (cnt_q == tq_t'(TQ_MAX)) begin
              val_d = cnt_q;
              st_d  = M_IDLE;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          default: st_d = M_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= M_IDLE;
      cnt_q     <= '0;
      val_q     <= '0;
      rx_prev_q <= 1'b1;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      val_q     <= val_d;
      rx_prev_q <= rx_prev_d;
    end
  end

  assign delay_val = val_q;

  // R1: an init quantum leaves the reported value at zero
  p_init_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_en && init) |=> (delay_val == '0));

  // R4: without a running measurement the reported value does not move
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_en && !init && st_q == M_IDLE) |=> $stable(delay_val));

  // R3: a running count never wraps back to zero
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_RUN) |-> (cnt_q != '0));
endmodule

// File: rtl/txdc_history.sv
module txdc_history
  import txdc_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tq_en,
  input  logic active,
  input  logic bit_start,
  input  logic tx_level,
  input  tq_t  ssp,
  output logic chk_vld,
  output logic chk_bit
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  typedef logic [AW-1:0] ptr_t;
  typedef logic [CW-1:0] cnt_t;

  slot_t mem_q [DEPTH];
  tq_t   now_q, now_d;
  ptr_t  rd_q, rd_d, wr_q, wr_d;
  cnt_t  n_q, n_d;
  logic  want_push, push, pop;
  tq_t   due_w;

  function automatic ptr_t ptr_next(input ptr_t p);
    return (p == ptr_t'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    want_push = tq_en & active & bit_start;
    push      = want_push & (n_q != cnt_t'(DEPTH));
    pop       = tq_en & active & (n_q != '0) & (mem_q[rd_q].due == now_q);
    due_w     = now_q + ssp;
    now_d     = tq_en ? now_q + 1'b1 : now_q;
    rd_d      = rd_q;
    wr_d      = wr_q;
    n_d       = n_q;
    if (tq_en && !active) begin
      rd_d = '0;
      wr_d = '0;
      n_d  = '0;
    end else begin
      if (push) wr_d = ptr_next(wr_q);
      if (pop)  rd_d = ptr_next(rd_q);
      n_d = n_q + cnt_t'(push) - cnt_t'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      n_q   <= '0;
    end else begin
      now_q <= now_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      n_q   <= n_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= '{bit_val: tx_level, due: due_w};
  end

  assign chk_vld = pop;
  assign chk_bit = mem_q[rd_q].bit_val;

  // R8: a legal configuration never launches into a full queue
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    want_push |-> (n_q != cnt_t'(DEPTH)));

  // R7: compares only happen inside an active data phase
  p_check_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld |-> (active && tq_en));
endmodule

// File: rtl/txdc_judge.sv
module txdc_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic tq_en,
  input  logic active,
  input  logic chk_vld,
  input  logic chk_bit,
  input  logic rx_level,
  input  logic sample_pt,
  output logic bit_err
);
  logic pend_q, pend_d;
  logic err_q, err_d;
  logic mismatch;

  assign mismatch = chk_vld & (chk_bit ^ rx_level);

  always_comb begin
    pend_d = pend_q;
    err_d  = 1'b0;
    if (tq_en) begin
      if (sample_pt) begin
        err_d  = pend_q;
        pend_d = mismatch;
      end else if (mismatch) begin
        pend_d = 1'b1;
      end
      if (!active) pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  assign bit_err = err_q;

  // R6: a report only follows a regular sample point quantum
  p_report_at_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> $past(tq_en && sample_pt));

  // R6: a pending error only arises from a compare that failed
  p_pend_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(chk_vld && (chk_bit != rx_level)));
endmodule

// File: rtl/txdc_top.sv
module txdc_top
  import txdc_pkg::*;
#(
  parameter int unsigned QDEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tq_en,
  input  logic            init,
  input  logic            comp_en,
  input  logic [TQ_W-1:0] tdc_offset,
  input  logic            tx_level,
  input  logic            rx_level,
  input  logic            fdf_edge,
  input  logic            bit_start,
  input  logic            data_phase,
  input  logic            sample_pt,
  output logic [TQ_W-1:0] delay_val,
  output logic            bit_err
);
  logic [1:0] rs_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  tq_t           meas_w;
  logic [TQ_W:0] sum_w;
  tq_t           ssp_w;
  logic          active_w;
  logic          chk_vld_w, chk_bit_w;

  always_comb begin
    sum_w = {1'b0, meas_w} + {1'b0, tdc_offset};
    if (sum_w > {1'b0, tq_t'(TQ_MAX)}) ssp_w = tq_t'(TQ_MAX);
    else if (sum_w == '0)              ssp_w = tq_t'(1);
    else                               ssp_w = sum_w[TQ_W-1:0];
    active_w = comp_en & data_phase & ~init;
  end

  txdc_meter u_meter (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .tq_en     (tq_en),
    .init      (init),
    .comp_en   (comp_en),
    .fdf_edge  (fdf_edge),
    .rx_level  (rx_level),
    .delay_val (meas_w)
  );

  txdc_history #(.DEPTH(QDEPTH)) u_hist (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .tq_en     (tq_en),
    .active    (active_w),
    .bit_start (bit_start),
    .tx_level  (tx_level),
    .ssp       (ssp_w),
    .chk_vld   (chk_vld_w),
    .chk_bit   (chk_bit_w)
  );

  txdc_judge u_judge (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .tq_en     (tq_en),
    .active    (active_w),
    .chk_vld   (chk_vld_w),
    .chk_bit   (chk_bit_w),
    .rx_level  (rx_level),
    .sample_pt (sample_pt),
    .bit_err   (bit_err)
  );

  assign delay_val = meas_w;

  // R5: the compare point stays inside the 1..127 quantum window
  p_ssp_window_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ssp_w != '0) && ({1'b0, ssp_w} <= sum_w || sum_w == '0));
endmodule

// File: tb/txdc_top_test.sv
module txdc_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tq_en, init, comp_en, tx_level, rx_level;
  logic       fdf_edge, bit_start, data_phase, sample_pt;
  logic [6:0] tdc_offset;
  logic [6:0] delay_val;
  logic       bit_err;

  int checks = 0;
  int errors = 0;
  int qn = 0;
  int exp_q[$];
  int cur_d = 1;
  int last_delay = 0;

  localparam int LEAD = 150;
  localparam int DSTART = 150;
  localparam int BT = 20;
  localparam int SPOS = 14;
  localparam int NBITS = 10;
  localparam int DEND = DSTART + (NBITS - 1) * BT + SPOS;

  always #10 clk = ~clk;

  txdc_top uut (
    .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .init(init), .comp_en(comp_en),
    .tdc_offset(tdc_offset), .tx_level(tx_level), .rx_level(rx_level),
    .fdf_edge(fdf_edge), .bit_start(bit_start), .data_phase(data_phase),
    .sample_pt(sample_pt), .delay_val(delay_val), .bit_err(bit_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (quantum %0d)", req, act, exp, qn);
    end
  endtask

  function automatic bit data_bit(input int j);
    return bit'(j[0] ^ j[1]);
  endfunction

  function automatic bit txf(input int f);
    if (f < 0) return 1'b1;
    if (f < DSTART) return 1'b0;
    if (f < DSTART + NBITS * BT) return data_bit((f - DSTART) / BT);
    return 1'b1;
  endfunction

  task automatic quantum(input bit tx, input bit rx, input bit fdf, input bit bst,
                         input bit dph, input bit spt);
    @(negedge clk);
    qn++;
    tx_level = tx; rx_level = rx; fdf_edge = fdf; bit_start = bst;
    data_phase = dph; sample_pt = spt; tq_en = 1'b1;
    @(negedge clk);
    tq_en = 1'b0; fdf_edge = 1'b0; bit_start = 1'b0; sample_pt = 1'b0; init = 1'b0;
  endtask

  // Monitor: every report is matched against the next expected quantum
  always @(negedge clk) begin
    if (rst_n === 1'b1 && bit_err === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6/R7 unexpected bit_err", qn, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(e == qn, "R6 bit_err quantum", qn, e);
      end
    end
  end

  // Driver: one frame, expected reports pushed before it runs
  task automatic run_frame(input int d, input int off, input bit en, input int inj,
                           input bit arb, input string tag);
    int meas, s, base, glf, arb_gl, last_rep;
    cur_d = d;
    comp_en = en;
    tdc_offset = 7'(off);
    meas = en ? ((d > 127) ? 127 : d) : last_delay;
    s = meas + off;
    if (s > 127) s = 127;
    if (s == 0) s = 1;
    glf = (inj >= 0) ? DSTART + inj * BT + s : -100000;
    arb_gl = -LEAD + s;
    base = qn + LEAD + 1;
    last_rep = -1;
    if (en) begin
      for (int j = 0; j < NBITS; j++) begin
        int ssp, rxv, rep;
        ssp = DSTART + j * BT + s;
        rxv = int'(txf(ssp - d)) ^ ((ssp == glf) ? 1 : 0);
        if (ssp <= DEND && rxv != int'(data_bit(j))) begin
          rep = -1;
          for (int k = 0; k < NBITS; k++) begin
            int sp;
            sp = DSTART + k * BT + SPOS;
            if (rep < 0 && sp > ssp) rep = sp;
          end
          if (rep >= 0 && rep != last_rep) begin
            exp_q.push_back(base + rep);
            last_rep = rep;
          end
        end
      end
    end
    for (int f = -LEAD; f < DSTART + NBITS * BT + 140; f++) begin
      bit tx, rx, bst, spt, dph;
      tx = txf(f);
      rx = txf(f - d);
      bst = 1'b0; spt = 1'b0;
      dph = (f >= DSTART && f <= DEND);
      if (f >= DSTART && f < DSTART + NBITS * BT) begin
        bst = ((f - DSTART) % BT == 0);
        spt = ((f - DSTART) % BT == SPOS);
      end
      if (arb && f < -20) begin
        bst = ((f + LEAD) % BT == 0);
        spt = ((f + LEAD) % BT == SPOS);
        if (f == arb_gl) rx = ~rx;
      end
      if (f == glf) rx = ~rx;
      quantum(tx, rx, f == 0, bst, dph, spt);
    end
    check(int'(delay_val) == meas, {tag, " delay_val"}, int'(delay_val), meas);
    check(exp_q.size() == 0, {tag, " all expected reports seen"}, exp_q.size(), 0);
    exp_q.delete();
    last_delay = meas;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", qn, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tq_en = 1'b0; init = 1'b0; comp_en = 1'b0; tx_level = 1'b1;
    rx_level = 1'b1; fdf_edge = 1'b0; bit_start = 1'b0; data_phase = 1'b0;
    sample_pt = 1'b0; tdc_offset = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(delay_val == 7'd0, "R1 reset delay_val", int'(delay_val), 0);
    check(bit_err == 1'b0, "R1 reset bit_err", int'(bit_err), 0);

    // R2 R5 R6: short loop, error reported at the next bit's sample point
    run_frame(7, 10, 1'b1, 2, 1'b0, "R2 R5 R6");
    // R6: compare coincides with a sample point, report deferred
    run_frame(4, 10, 1'b1, 1, 1'b0, "R6 same-quantum");
    // R3 R8: loop longer than 127, saturated value, seven bits in flight
    run_frame(130, 5, 1'b1, 0, 1'b0, "R3 R8 saturate");
    // R5: sum above 127 is capped
    run_frame(120, 10, 1'b1, 3, 1'b0, "R5 cap");
    // R7: compare point after the data phase ends is discarded
    run_frame(90, 5, 1'b1, 9, 1'b0, "R7 end of data");
    // R4 R7: compensation off, no measurement and no checking
    run_frame(33, 10, 1'b0, 2, 1'b0, "R4 R7 disabled");
    // R7: strobes and a mismatch outside the data phase are ignored
    run_frame(12, 20, 1'b1, -1, 1'b1, "R7 arbitration");

    // R1: init clears the measured value
    init = 1'b1;
    quantum(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check(delay_val == 7'd0, "R1 init clears delay_val", int'(delay_val), 0);
    last_delay = 0;
    run_frame(9, 3, 1'b1, 4, 1'b0, "R2 R6 after init");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule